// File: doc/BRIEF.md
# Nanosecond Real-Time Clock with Alarm

This block is a memory-mapped real-time clock. A 64-bit counter holds the time in nanoseconds and gains a fixed number of nanoseconds on every clock, set by the parameter `NS_PER_CLK`. Software can read the counter and overwrite either half of it through a 32-bit register port. The port has a byte offset, a write strobe, write data, a read strobe and registered read data.

Reading the low time word also stores the upper word in a holding register. A later read of the high word therefore returns a value that matches the low word read earlier, even when a carry has happened in between.

A single 64-bit alarm raises a level interrupt. The interrupt fires as soon as the counter is at or past the armed value. Only a write to the alarm's low word arms it, and an alarm set in the past fires at once. The interrupt line is the pending flag gated by an enable bit. Software clears the pending flag and can cancel a running alarm by writing to dedicated registers.

Top module: `nsrtc_top`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears the counter, the stored alarm value, the armed target, the running flag, the pending flag, the enable bit, the high-word holding register and the read data. After reset, `irq` is 0 and offsets 0x04, 0x08, 0x0C, 0x10 and 0x18 read 0.
- R2: Outside reset and with no time write, the counter grows by `NS_PER_CLK` (default 10) on every clock edge. It wraps modulo 2^64.
- R3: A read of offset 0x00 returns counter bits 31:0 as they stand at that edge. The same edge loads counter bits 63:32 into the holding register. A read of offset 0x04 returns the holding register, not the live upper word.
- R4: A write to offset 0x00 sets counter bits 31:0 to the data and keeps bits 63:32. A write to offset 0x04 sets bits 63:32 to the data. During that cycle bits 31:0 still advance by `NS_PER_CLK`, and no carry passes into the new upper word.
- R5: A write to offset 0x0C stores only the alarm's upper word and never arms. A write to offset 0x08 stores the lower word and arms with the full 64-bit value. Offsets 0x08 and 0x0C read back the stored lower and upper words.
- R6: When the alarm is armed, if the new 64-bit value is less than or equal to the counter at that edge, running is 0 and pending is set at that edge. Otherwise running is set.
- R7: While running, at the first edge where the counter is greater than or equal to the armed target, running clears and pending sets together. The armed target is latched at arming, so a later write to 0x0C changes what 0x0C reads but not when the running alarm fires.
- R8: `irq` is 1 exactly when both the pending flag and the enable bit are 1. A write to 0x10 keeps only data bit 0, and 0x10 reads back that bit in position 0.
- R9: The written data is ignored at both of these offsets.
  - A write to 0x14 clears running. It wins over a fire in the same cycle.
  - A write to 0x1C clears pending, but a fire in the same cycle still sets it.
  - Pending otherwise stays set until cleared.
- R10: Offset 0x18 reads 1 in bit 0 while an alarm is running and 0 otherwise.
- R11: Offsets 0x14, 0x1C and 0x20 to 0x3C read 0, and any offset with bits 1:0 nonzero reads 0. Writes to offsets 0x20 to 0x3C or with bits 1:0 nonzero change nothing.
- R12: `rd_data` takes the selected value at the edge where `rd_en` is sampled high and holds it until the next read. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W (6) | Byte offset of the access |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wr_data | input | DATA_W (32) | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W (32) | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Level interrupt: pending AND enable |

## Verification
The bench checks the split read across a carry out of the low word.
- A design that did not hold the upper word would return the new high value after the wrap instead of the captured one.
- A design that did not keep the armed target would delay the fire after a late write to the upper alarm word.

It arms an alarm equal to the counter at the write edge to catch a strict compare that would leave the alarm running. It checks that a write to the upper alarm word alone never arms. It also checks that a cancelled alarm never fires and that the pending flag stays set while masked. Further checks confirm that the enable register drops all but bit 0 and that misaligned or unmapped writes leave state untouched.

// File: rtl/nsrtc_pkg.sv
package nsrtc_pkg;

    // Word slot numbers: byte offset divided by four.
    localparam int unsigned SLOT_TIME_LO  = 0;
    localparam int unsigned SLOT_TIME_HI  = 1;
    localparam int unsigned SLOT_ALM_LO   = 2;
    localparam int unsigned SLOT_ALM_HI   = 3;
    localparam int unsigned SLOT_IRQ_EN   = 4;
    localparam int unsigned SLOT_ALM_STOP = 5;
    localparam int unsigned SLOT_ALM_STAT = 6;
    localparam int unsigned SLOT_IRQ_ACK  = 7;

    // Decoded write strobes, one per writable slot.
    typedef struct packed {
        logic time_lo;
        logic time_hi;
        logic alm_lo;
        logic alm_hi;
        logic irq_en;
        logic alm_stop;
        logic irq_ack;
    } wr_strobe_t;

endpackage

// File: rtl/nsrtc_counter.sv
module nsrtc_counter #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned NS_PER_CLK = 10,
    localparam int unsigned CNT_W     = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_lo,
    input  logic              set_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  count
);

    typedef struct packed {
        logic [CNT_W-1:0] ns;
    } cnt_state_t;

    cnt_state_t       state_d, state_q;
    logic [CNT_W-1:0] stepped;

    always_comb begin
        stepped = state_q.ns + CNT_W'(NS_PER_CLK);
        state_d = state_q;
        if (set_lo) begin
            state_d.ns = {state_q.ns[CNT_W-1:DATA_W], wdata};
        end else if (set_hi) begin
            state_d.ns = {wdata, stepped[DATA_W-1:0]};
        end else begin
            state_d.ns = stepped;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count = state_q.ns;

endmodule

// File: rtl/nsrtc_alarm.sv
module nsrtc_alarm #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  count,
    input  logic              set_lo,
    input  logic              set_hi,
    input  logic              stop,
    input  logic              ack,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  alarm_val,
    output logic [CNT_W-1:0]  target,
    output logic              running,
    output logic              pending
);

    typedef struct packed {
        logic [CNT_W-1:0] stored;
        logic [CNT_W-1:0] armed;
        logic             run;
        logic             pend;
    } alm_state_t;

    alm_state_t       state_d, state_q;
    logic [CNT_W-1:0] new_val;
    logic             reached;
    logic             fire_now;

    always_comb begin
        new_val  = {state_q.stored[CNT_W-1:DATA_W], wdata};
        reached  = (count >= state_q.armed);
        fire_now = state_q.run && reached && !set_lo && !stop;
        state_d  = state_q;

        if (set_hi) begin
            state_d.stored[CNT_W-1:DATA_W] = wdata;
        end

        if (set_lo) begin
            state_d.stored = new_val;
            state_d.armed  = new_val;
            if (new_val <= count) begin
                state_d.run  = 1'b0;
                state_d.pend = 1'b1;
            end else begin
                state_d.run  = 1'b1;
            end
        end else if (stop) begin
            state_d.run = 1'b0;
        end

        if (ack) begin
            state_d.pend = 1'b0;
        end

        // A fire in the same cycle as an acknowledge wins.
        if (fire_now) begin
            state_d.run  = 1'b0;
            state_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign alarm_val = state_q.stored;
    assign target    = state_q.armed;
    assign running   = state_q.run;
    assign pending   = state_q.pend;

endmodule

// File: rtl/nsrtc_regif.sv
module nsrtc_regif
    import nsrtc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 6,
    localparam int unsigned CNT_W  = 2 * DATA_W,
    localparam int unsigned WORD_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              en_bit,
    input  logic              rd_en,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  alarm_val,
    input  logic              running,
    output wr_strobe_t        strobe,
    output logic              enable,
    output logic [DATA_W-1:0] hold,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic              en;
        logic [DATA_W-1:0] rdata;
    } reg_state_t;

    reg_state_t        state_d, state_q;
    logic              aligned;
    logic [WORD_W-1:0] word;
    logic [DATA_W-1:0] rd_mux;

    function automatic logic at_slot(input logic [WORD_W-1:0] w, input int unsigned k);
        return w == WORD_W'(k);
    endfunction

    always_comb begin
        aligned = (addr[1:0] == 2'b00);
        word    = addr[ADDR_W-1:2];

        strobe.time_lo  = wr_en && aligned && at_slot(word, SLOT_TIME_LO);
        strobe.time_hi  = wr_en && aligned && at_slot(word, SLOT_TIME_HI);
        strobe.alm_lo   = wr_en && aligned && at_slot(word, SLOT_ALM_LO);
        strobe.alm_hi   = wr_en && aligned && at_slot(word, SLOT_ALM_HI);
        strobe.irq_en   = wr_en && aligned && at_slot(word, SLOT_IRQ_EN);
        strobe.alm_stop = wr_en && aligned && at_slot(word, SLOT_ALM_STOP);
        strobe.irq_ack  = wr_en && aligned && at_slot(word, SLOT_IRQ_ACK);

        rd_mux = '0;
        if (aligned) begin
            if (at_slot(word, SLOT_TIME_LO)) begin
                rd_mux = count[DATA_W-1:0];
            end else if (at_slot(word, SLOT_TIME_HI)) begin
                rd_mux = state_q.hold;
            end else if (at_slot(word, SLOT_ALM_LO)) begin
                rd_mux = alarm_val[DATA_W-1:0];
            end else if (at_slot(word, SLOT_ALM_HI)) begin
                rd_mux = alarm_val[CNT_W-1:DATA_W];
            end else if (at_slot(word, SLOT_IRQ_EN)) begin
                rd_mux = DATA_W'(state_q.en);
            end else if (at_slot(word, SLOT_ALM_STAT)) begin
                rd_mux = DATA_W'(running);
            end
        end

        state_d = state_q;
        if (rd_en) begin
            state_d.rdata = rd_mux;
            if (aligned && at_slot(word, SLOT_TIME_LO)) begin
                state_d.hold = count[CNT_W-1:DATA_W];
            end
        end
        if (strobe.irq_en) begin
            state_d.en = en_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign enable  = state_q.en;
    assign hold    = state_q.hold;
    assign rd_data = state_q.rdata;

endmodule

// File: rtl/nsrtc_top.sv
module nsrtc_top
    import nsrtc_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 6,
    parameter int unsigned NS_PER_CLK = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    localparam int unsigned CNT_W = 2 * DATA_W;

    wr_strobe_t        strobe;
    logic [CNT_W-1:0]  time_ns;
    logic [CNT_W-1:0]  alarm_val;
    logic [CNT_W-1:0]  alarm_target;
    logic              alarm_run;
    logic              irq_pend;
    logic              irq_en;
    logic [DATA_W-1:0] time_hi_hold;

    nsrtc_regif #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) i_regif (
        .clk       (clk),
        .rst       (rst),
        .addr      (addr),
        .wr_en     (wr_en),
        .en_bit    (wr_data[0]),
        .rd_en     (rd_en),
        .count     (time_ns),
        .alarm_val (alarm_val),
        .running   (alarm_run),
        .strobe    (strobe),
        .enable    (irq_en),
        .hold      (time_hi_hold),
        .rd_data   (rd_data)
    );

    nsrtc_counter #(
        .DATA_W     (DATA_W),
        .NS_PER_CLK (NS_PER_CLK)
    ) i_counter (
        .clk    (clk),
        .rst    (rst),
        .set_lo (strobe.time_lo),
        .set_hi (strobe.time_hi),
        .wdata  (wr_data),
        .count  (time_ns)
    );

    nsrtc_alarm #(
        .DATA_W (DATA_W)
    ) i_alarm (
        .clk       (clk),
        .rst       (rst),
        .count     (time_ns),
        .set_lo    (strobe.alm_lo),
        .set_hi    (strobe.alm_hi),
        .stop      (strobe.alm_stop),
        .ack       (strobe.irq_ack),
        .wdata     (wr_data),
        .alarm_val (alarm_val),
        .target    (alarm_target),
        .running   (alarm_run),
        .pending   (irq_pend)
    );

    assign irq = irq_pend & irq_en;

endmodule

// File: rtl/nsrtc_chk.sv
module nsrtc_chk #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 6,
    parameter int unsigned NS_PER_CLK = 10,
    localparam int unsigned CNT_W     = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  alarm_val,
    input logic [CNT_W-1:0]  target,
    input logic              running,
    input logic              pending,
    input logic              enable,
    input logic [DATA_W-1:0] hold
);

    logic       past_ok;
    logic [3:0] slot;
    logic       aligned;
    logic       time_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    assign aligned = (addr[1:0] == 2'b00);
    assign slot    = 4'(addr[ADDR_W-1:2]);
    assign time_wr = wr_en && aligned && (slot == 4'd0 || slot == 4'd1);

    // R2: the count steps by the fixed increment when no time write happened
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(time_wr)) |-> (count == $past(count) + CNT_W'(NS_PER_CLK)));

    // R3: a low-word read captures the upper word
    p_hold_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(rd_en && aligned && slot == 4'd0)) |-> (hold == $past(count[CNT_W-1:DATA_W])));

    // R6: arming with a future value leaves the alarm running
    p_arm_future_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && aligned && slot == 4'd2 && ({alarm_val[CNT_W-1:DATA_W], wr_data} > count)) |=> running);

    // R7: reaching the target ends running and sets pending together
    p_fire_r7: assert property (@(posedge clk) disable iff (rst)
        (running && (count >= target) && !wr_en) |=> (pending && !running));

    // R8: only bit 0 of an enable write is kept
    p_enable_bit_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && aligned && slot == 4'd4) |=> (enable == $past(wr_data[0])));

    // R9: acknowledge clears pending when no fire coincides
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && aligned && slot == 4'd7 && !(running && count >= target)) |=> !pending);

    // R9: pending is sticky without an acknowledge
    p_pend_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (pending && !(wr_en && aligned && slot == 4'd7)) |=> pending);

endmodule

bind nsrtc_top nsrtc_chk #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .NS_PER_CLK (NS_PER_CLK)
) i_nsrtc_chk (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .count     (time_ns),
    .alarm_val (alarm_val),
    .target    (alarm_target),
    .running   (alarm_run),
    .pending   (irq_pend),
    .enable    (irq_en),
    .hold      (time_hi_hold)
);

// File: tb/test_nsrtc_top.sv
module test_nsrtc_top;

    localparam int CLK_PERIOD = 10;
    localparam int NS         = 10;

    localparam logic [5:0] A_TLO  = 6'h00;
    localparam logic [5:0] A_THI  = 6'h04;
    localparam logic [5:0] A_ALO  = 6'h08;
    localparam logic [5:0] A_AHI  = 6'h0C;
    localparam logic [5:0] A_EN   = 6'h10;
    localparam logic [5:0] A_STOP = 6'h14;
    localparam logic [5:0] A_STAT = 6'h18;
    localparam logic [5:0] A_ACK  = 6'h1C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    exp_t        cur;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [63:0] m_cnt;
    logic [31:0] a_lo;
    bit          mon_flag = 1'b0;
    bit          done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nsrtc_top #(
        .DATA_W     (32),
        .ADDR_W     (6),
        .NS_PER_CLK (NS)
    ) i_nsrtc_top (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .irq     (irq)
    );

    // Counter model built from R2 and R4
    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= '0;
        end else if (wr_en && addr == A_TLO) begin
            m_cnt <= {m_cnt[63:32], wr_data};
        end else if (wr_en && addr == A_THI) begin
            m_cnt <= {wr_data, m_cnt[31:0] + 32'(NS)};
        end else begin
            m_cnt <= m_cnt + 64'(NS);
        end
    end

    // Monitor: one read result per sampled strobe
    always @(posedge clk) mon_flag <= rd_en;

    always @(negedge clk) begin
        if (mon_flag) begin
            n_chk++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL R12 unexpected read data actual=%h expected=none", rd_data);
            end else begin
                cur = sb_q.pop_front();
                if (rd_data !== cur.exp) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", cur.tag, rd_data, cur.exp);
                end
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        sb_q.push_back('{e, tag});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_lo(input string tag);
        @(negedge clk);
        addr = A_TLO; rd_en = 1'b1;
        sb_q.push_back('{m_cnt[31:0], tag});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic arm_rel(input logic [31:0] delta);
        @(negedge clk);
        a_lo = m_cnt[31:0] + delta;
        addr = A_ALO; wr_data = a_lo; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        n_chk++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_irq(1'b0, "R1 irq after reset");
        rd(A_EN,   32'h0, "R1 enable after reset");
        rd(A_STAT, 32'h0, "R1 status after reset");
        rd(A_ALO,  32'h0, "R1 alarm low after reset");
        rd(A_AHI,  32'h0, "R1 alarm high after reset");
        rd(A_THI,  32'h0, "R1 hold after reset");

        // R2 free running count
        rd_lo("R2 count first sample");
        repeat (17) @(negedge clk);
        rd_lo("R2 count second sample");

        // R4 half writes
        wr(A_TLO, 32'h0000_1000);
        rd_lo("R4 low half replaced");
        wr(A_THI, 32'h0000_1234);
        rd_lo("R4 low keeps counting after high write");
        rd(A_THI, 32'h0000_1234, "R4 high half replaced");

        // R3 split read across a carry
        wr(A_THI, 32'd5);
        wr(A_TLO, 32'hFFFF_FF00);
        rd_lo("R3 low before carry");
        repeat (40) @(negedge clk);
        rd(A_THI, 32'd5, "R3 held high survives carry");
        rd_lo("R3 low after carry");
        rd(A_THI, 32'd6, "R3 recaptured high");

        // R11 unmapped and misaligned
        wr(6'h20, 32'hFFFF_FFFF);
        wr(6'h11, 32'h1);
        rd(A_EN,   32'h0, "R11 stray writes leave enable");
        rd(6'h20,  32'h0, "R11 unmapped reads zero");
        rd(A_STOP, 32'h0, "R11 stop offset reads zero");
        rd(A_ACK,  32'h0, "R11 ack offset reads zero");

        // R8 enable bit
        wr(A_EN, 32'hFFFF_FFFE);
        rd(A_EN, 32'h0, "R8 enable keeps bit 0 only");
        wr(A_EN, 32'h3);
        rd(A_EN, 32'h1, "R8 enable set");

        // Known time base for alarms
        wr(A_THI, 32'h0);
        wr(A_TLO, 32'h0001_0000);
        wr(A_AHI, 32'h0);
        rd(A_STAT, 32'h0, "R5 high write alone does not arm");

        // R6 past alarm
        wr(A_ALO, 32'h100);
        chk_irq(1'b1, "R6 past alarm fires at once");
        rd(A_STAT, 32'h0, "R6 past alarm not running");

        // R9 sticky and acknowledge
        repeat (20) @(negedge clk);
        chk_irq(1'b1, "R9 pending sticky");
        wr(A_ACK, 32'h0);
        chk_irq(1'b0, "R9 acknowledge clears");

        // R8 gating
        wr(A_EN, 32'h0);
        wr(A_ALO, 32'h100);
        chk_irq(1'b0, "R8 masked pending");
        wr(A_EN, 32'h1);
        chk_irq(1'b1, "R8 unmasked pending");
        wr(A_ACK, 32'hFFFF_FFFF);
        chk_irq(1'b0, "R9 ack data ignored");

        // R6 equality fires at once
        @(negedge clk);
        addr = A_ALO; wr_data = m_cnt[31:0]; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk_irq(1'b1, "R6 equal value fires");
        rd(A_STAT, 32'h0, "R6 equal value not running");
        wr(A_ACK, 32'h0);

        // R10 and R7 future alarm, target 50 cycles ahead
        arm_rel(32'd500);
        rd(A_STAT, 32'h1, "R10 status while running");
        rd(A_ALO, a_lo, "R5 alarm low readback");
        repeat (41) @(negedge clk);
        chk_irq(1'b0, "R7 no fire before target");
        repeat (7) @(negedge clk);
        chk_irq(1'b1, "R7 fire after target");
        rd(A_STAT, 32'h0, "R10 status after fire");
        wr(A_ACK, 32'h0);

        // R7 armed target kept after a high write
        arm_rel(32'd500);
        wr(A_AHI, 32'd7);
        rd(A_AHI, 32'd7, "R5 alarm high readback");
        repeat (55) @(negedge clk);
        chk_irq(1'b1, "R7 armed target kept");
        wr(A_ACK, 32'h0);
        wr(A_AHI, 32'h0);

        // R9 stop a running alarm
        arm_rel(32'd500);
        rd(A_STAT, 32'h1, "R9 running before stop");
        wr(A_STOP, 32'hDEAD_BEEF);
        rd(A_STAT, 32'h0, "R9 stopped");
        repeat (60) @(negedge clk);
        chk_irq(1'b0, "R9 stopped alarm never fires");

        // R12 read with simultaneous write returns old value, then holds
        @(negedge clk);
        addr = A_EN; wr_data = 32'h0; wr_en = 1'b1; rd_en = 1'b1;
        sb_q.push_back('{32'h1, "R12 read sees pre-write value"});
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        rd(A_EN, 32'h0, "R12 write took effect");
        repeat (3) @(negedge clk);
        n_chk++;
        if (rd_data !== 32'h0) begin
            n_fail++;
            $display("FAIL R12 read data hold actual=%h expected=%h", rd_data, 32'h0);
        end

        repeat (2) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R12 missing read results actual=%0d expected=0", sb_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule